// File: doc/BRIEF.md
# Periodic Down-Counting Interrupt Timer

This block is a programmable down counter that raises a periodic interrupt for a host processor. A prescaler divides the system clock into a fixed tick, nominally 100 µs, and the counter moves down by one on each tick while the timer is enabled. When the count reaches zero, the next tick wraps it to the all-ones value and counting continues. The wrap is the interrupt event.

Software works the block through four 32-bit registers, selected by a 2-bit address. A single-cycle write strobe carries address and data, and the read data follows the read address combinationally.

- **Address 0** is the configuration word. Bits 15:0 hold the preload, bit 16 holds the enable, and all other bits read zero.
- **Address 1** is the read-only count.
- **Address 2** is the sticky interrupt status in bit 0, cleared by writing one.
- **Address 3** is the interrupt enable in bit 0.

The tick period is a parameter counted in system clock cycles, so a short period can be used in simulation.

Top module: `ptimer_top`

## Requirements
- R1: After reset the configuration register reads 0x0000FFFF (preload FFFFh, enable 0), the count reads 0xFFFF, status and interrupt enable read 0, and `irq` is low.
- R2: A configuration write with bit 16 set loads the count with bits 15:0 at that clock edge and restarts the prescaler. This holds both when the timer is being enabled and when it is already running.
- R3: While enabled, the count drops by one every TICK_CYC clock cycles. The first drop comes TICK_CYC cycles after the loading write.
- R4: A tick taken at count 0000h sets the count to FFFFh, and the timer keeps counting down from there.
- R5: A configuration write that clears bit 16 while the timer is enabled sets the preload to FFFFh, whatever bits 15:0 carried. A configuration write with bit 16 clear while the timer is already disabled stores bits 15:0 as the preload and leaves the count untouched.
- R6: While disabled, the count holds its value and the prescaler is held cleared.
- R7: A wrap sets status bit 0 (address 2) only when interrupt enable bit 0 (address 3) is 1. A wrap with the enable at 0 leaves status at 0.
- R8: Status is sticky. Writing 1 to bit 0 of address 2 clears it, and writing 0 there has no effect.
- R9: When a wrap with the interrupt enable set coincides with a clearing write to status, status ends at 1.
- R10: `irq` is high exactly when status bit 0 and interrupt enable bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same clock edge: the wrap that sets the sticky status and a host write of one that clears it. The bench provokes this by loading the count with zero and counting the prescaler cycles from that write. It then issues the clearing status write so that it is sampled on exactly the edge where the wrap tick lands. Status must read 1 afterwards while the count reads FFFFh, which shows that the set took priority rather than the clear or neither.

// File: rtl/ptimer_pkg.sv
`timescale 1ns/100ps
package ptimer_pkg;
   localparam int REG_ADDR_W = 2;
   localparam logic [REG_ADDR_W-1:0] A_CFG = 2'd0;
   localparam logic [REG_ADDR_W-1:0] A_CNT = 2'd1;
   localparam logic [REG_ADDR_W-1:0] A_STS = 2'd2;
   localparam logic [REG_ADDR_W-1:0] A_IEN = 2'd3;
endpackage

// File: rtl/ptimer_prescale.sv
`timescale 1ns/100ps
module ptimer_prescale #(
   parameter int TICK_CYC = 12500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   if (TICK_CYC < 1) begin : g_bad
      $error("TICK_CYC must be at least 1");
   end

   if (TICK_CYC == 1) begin : g_pass
      assign tick = run;
   end else begin : g_div
      localparam int PW = $clog2(TICK_CYC);
      localparam logic [PW-1:0] LAST = PW'(TICK_CYC - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                pre_q <= '0;
         else if (!run || restart)  pre_q <= '0;
         else if (pre_q == LAST)    pre_q <= '0;
         else                       pre_q <= pre_q + 1'b1;
      end

      assign tick = run && (pre_q == LAST);

      // R3
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
      // R6
      held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !run |=> pre_q == '0);
   end
endmodule

// File: rtl/ptimer_counter.sv
`timescale 1ns/100ps
module ptimer_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;

   assign wrap = tick && !load && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '1;
      else if (load)  cnt_q <= load_val;
      else if (tick)  cnt_q <= cnt_q - 1'b1;
   end

   assign cnt = cnt_q;

   // R2
   load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == $past(load_val));
   // R3
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q - 1'b1));
   // R4
   wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> &cnt_q);
   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/ptimer_status.sv
`timescale 1ns/100ps
module ptimer_status (
   input  logic clk,
   input  logic rst_n,
   input  logic ev,
   input  logic ien_wr,
   input  logic ien_val,
   input  logic clr,
   output logic sts,
   output logic ien,
   output logic irq
);
   logic sts_q, ien_q, set_now;

   assign set_now = ev && ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sts_q <= 1'b0;
      else if (set_now) sts_q <= 1'b1;
      else if (clr)     sts_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien_q <= 1'b0;
      else if (ien_wr) ien_q <= ien_val;
   end

   assign sts = sts_q;
   assign ien = ien_q;
   assign irq = sts_q && ien_q;

   // R7
   gated_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q) |-> $past(ien_q) && $past(ev));
   // R8
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q && !clr) |=> sts_q);
   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && ien_q && clr) |=> sts_q);
endmodule

// File: rtl/ptimer_top.sv
`timescale 1ns/100ps
module ptimer_top #(
   parameter int TICK_CYC = 12500,
   parameter int CNT_W    = 16,
   parameter int DATA_W   = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ptimer_pkg::REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic [ptimer_pkg::REG_ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]               rd_data,
   output logic                            irq
);
   import ptimer_pkg::*;

   localparam int EN_BIT = CNT_W;

   if (DATA_W < CNT_W + 1) begin : g_bad_w
      $error("DATA_W must hold the preload field plus the enable bit");
   end

   logic             en_q, new_en, cfg_wr, load, tick, wrap;
   logic             sts, ien;
   logic [CNT_W-1:0] preload_q, cnt;

   assign cfg_wr = wr_en && (wr_addr == A_CFG);
   assign new_en = wr_data[EN_BIT];
   assign load   = cfg_wr && new_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         preload_q <= '1;
      end else if (cfg_wr) begin
         en_q <= new_en;
         if (en_q && !new_en) preload_q <= '1;
         else                 preload_q <= wr_data[CNT_W-1:0];
      end
   end

   ptimer_prescale #(.TICK_CYC(TICK_CYC)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(en_q), .restart(load), .tick(tick));

   ptimer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_data[CNT_W-1:0]),
      .tick(tick), .cnt(cnt), .wrap(wrap));

   ptimer_status u_sts (
      .clk(clk), .rst_n(rst_n), .ev(wrap),
      .ien_wr(wr_en && (wr_addr == A_IEN)), .ien_val(wr_data[0]),
      .clr(wr_en && (wr_addr == A_STS) && wr_data[0]),
      .sts(sts), .ien(ien), .irq(irq));

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CFG: begin
            rd_data[CNT_W-1:0] = preload_q;
            rd_data[EN_BIT]    = en_q;
         end
         A_CNT:   rd_data[CNT_W-1:0] = cnt;
         A_STS:   rd_data[0] = sts;
         default: rd_data[0] = ien;
      endcase
   end

   // R5
   drop_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && en_q && !new_en) |=> &preload_q);
   // R10
   irq_needs_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ien);
endmodule

// File: tb/sim_ptimer_top.sv
`timescale 1ns/100ps
module sim_ptimer_top;
   localparam int TCK = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   typedef struct {
      bit          is_irq;
      logic [1:0]  addr;
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ptimer_top #(.TICK_CYC(TCK)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

   // monitor: pops expected items and compares against the design
   initial begin
      forever begin
         wait (q.size() != 0);
         #0.2;
         begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = it.is_irq ? {31'b0, irq} : rd_data;
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: addr %0d irq=%0b actual %h expected %h",
                        it.req, it.addr, it.is_irq, act, it.exp);
            end
         end
      end
   end

   task automatic peek(input logic [1:0] a, input logic [31:0] e, input string r);
      item_t it;
      rd_addr = a;
      it.is_irq = 1'b0; it.addr = a; it.exp = e; it.req = r;
      q.push_back(it);
      #0.5;
   endtask

   task automatic peek_irq(input bit e, input string r);
      item_t it;
      it.is_irq = 1'b1; it.addr = '0; it.exp = {31'b0, e}; it.req = r;
      q.push_back(it);
      #0.5;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      peek(2'd0, 32'h0000_FFFF, "R1 cfg");
      peek(2'd1, 32'h0000_FFFF, "R1 count");
      peek(2'd2, 32'h0, "R1 status");
      peek(2'd3, 32'h0, "R1 ien");
      peek_irq(1'b0, "R1 irq");

      wr(2'd3, 32'h1);
      wr(2'd0, 32'h0001_0002);
      peek(2'd1, 32'h2, "R2 load on enable");
      step(3);
      peek(2'd1, 32'h2, "R3 no drop before period");
      step(1);
      peek(2'd1, 32'h1, "R3 first drop");
      step(4);
      peek(2'd1, 32'h0, "R3 second drop");
      peek(2'd2, 32'h0, "R7 no status before wrap");
      step(4);
      peek(2'd1, 32'h0000_FFFF, "R4 wrap to top");
      peek(2'd2, 32'h1, "R7 status set on wrap");
      peek_irq(1'b1, "R10 irq with status and ien");
      step(4);
      peek(2'd1, 32'h0000_FFFE, "R4 keeps counting");

      wr(2'd2, 32'h0);
      peek(2'd2, 32'h1, "R8 write zero ignored");
      wr(2'd2, 32'h1);
      peek(2'd2, 32'h0, "R8 write one clears");
      peek_irq(1'b0, "R10 irq low after clear");

      wr(2'd0, 32'h0001_0005);
      peek(2'd1, 32'h5, "R2 reload while running");
      peek(2'd0, 32'h0001_0005, "R2 cfg readback");
      wr(2'd0, 32'h0000_1234);
      peek(2'd0, 32'h0000_FFFF, "R5 preload reset on disable");
      peek(2'd1, 32'h5, "R6 count after disable");
      step(10);
      peek(2'd1, 32'h5, "R6 count holds while disabled");
      wr(2'd0, 32'h0000_0003);
      peek(2'd0, 32'h0000_0003, "R5 preload write while disabled");
      peek(2'd1, 32'h5, "R5 no load while disabled");
      wr(2'd0, 32'h0001_0003);
      peek(2'd1, 32'h3, "R2 load on re-enable");

      wr(2'd3, 32'h0);
      wr(2'd0, 32'h0001_0000);
      step(4);
      peek(2'd1, 32'h0000_FFFF, "R4 wrap with ien off");
      peek(2'd2, 32'h0, "R7 status gated by ien");
      peek_irq(1'b0, "R10 irq low with ien off");

      wr(2'd3, 32'h1);
      wr(2'd0, 32'h0001_0000);
      step(3);
      wr(2'd2, 32'h1);
      peek(2'd1, 32'h0000_FFFF, "R9 wrap landed on clear edge");
      peek(2'd2, 32'h1, "R9 set beats clear");
      peek_irq(1'b1, "R10 irq high after collision");
      wr(2'd3, 32'h0);
      peek_irq(1'b0, "R10 irq drops with ien");
      peek(2'd2, 32'h1, "R10 status kept when ien drops");

      step(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule